// File: doc/BRIEF.md
# Address-Latch Multicart PRG Bank Mapper

This block holds the banking logic for an 8-bit console multicart that carries 1 MiB of PRG-ROM and 8 KiB of CHR-RAM with no banking. The bank register is unusual because it is loaded from the CPU address bus, not from the data bus. Any CPU write that lands in the upper half of the address space ($8000-$FFFF) copies the low eleven address bits into the register. The data value of that write plays no part in it.

From this register the block builds the 20-bit PRG-ROM address. It can give a switchable 16 KiB window with either inner bank 0 or inner bank 7 fixed above it, a single 16 KiB bank seen in both halves, or one 32 KiB bank. It also selects the nametable mirroring and decides whether CHR-RAM may be written. Four solder-pad inputs can replace the lowest PRG address bits, so one menu image can offer several different game lists.

Top module: `mcm_prg_mapper`

## Requirements
- R1: A CPU write (strobe high, rw low) with address bit 15 set loads the register on that clock edge from CPU address bits 10..0. Register bit 0 is S, bit 1 is mirroring, bits 4,3,2 are the inner bank (A16..A14), bits 8,6,5 are the outer bank (A19..A17), bit 7 is O, bit 9 is L and bit 10 is the pad enable.
- R2: Reads, and writes with address bit 15 clear, leave the register unchanged.
- R3: When CPU A14=0, PRG A16..A14 equals the inner bank, except that A14 is forced to 0 when S=1. PRG A19..A17 always equals the outer bank.
- R4: When CPU A14=1 and O=1, PRG A16..A14 equals the inner bank if S=0. If S=1, A16..A15 come from the inner bank and A14 is 1.
- R5: When CPU A14=1 and O=0, all three of PRG A16..A14 equal L (0 gives inner bank 0, 1 gives inner bank 7).
- R6: PRG A13..A4 equal CPU A13..A4. PRG A3..A0 equal the pad inputs when register bit 10 is 1, and equal CPU A3..A0 otherwise.
- R7: The CHR-RAM write enable is high exactly when register bit 7 (O) is 0.
- R8: The CIRAM A10 output follows PPU A10 when register bit 1 is 0 (vertical) and PPU A11 when it is 1 (horizontal).
- R9: The PRG-ROM select is high only for a strobed CPU read with address bit 15 set.
- R10: Reset clears every register bit, so both 16 KiB halves map inner bank 0 of outer bank 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_strobe | input | 1 | CPU bus cycle valid |
| pad_sel | input | 4 | Solder-pad menu selection |
| ppu_a10 | input | 1 | PPU address bit 10 |
| ppu_a11 | input | 1 | PPU address bit 11 |
| prg_addr | output | 20 | PRG-ROM address |
| prg_sel | output | 1 | PRG-ROM select |
| ciram_a10 | output | 1 | Nametable page select |
| chr_wr_ok | output | 1 | CHR-RAM write enable |

## Verification
The bench builds the block with its default parameters: a 16-bit CPU bus, a 4-bit pad field and a 20-bit PRG address. With these widths the register has only 2048 possible values, so the bench writes every one of them. After each write it reads addresses in both halves and checks the PRG address, the mirroring and the CHR-RAM enable against arithmetic expectations, with a pad pattern that changes from value to value. Writes below $8000 and reads in the upper half are applied to show that they leave the register alone, and a reset in the middle of the run returns the block to bank 0.

// File: rtl/mcm_pkg.sv
package mcm_pkg;
   localparam int unsigned REG_W  = 11;
   localparam int unsigned F_SEL  = 0;
   localparam int unsigned F_MIR  = 1;
   localparam int unsigned F_IN0  = 2;
   localparam int unsigned F_IN1  = 3;
   localparam int unsigned F_IN2  = 4;
   localparam int unsigned F_OUT0 = 5;
   localparam int unsigned F_OUT1 = 6;
   localparam int unsigned F_LAY  = 7;
   localparam int unsigned F_OUT2 = 8;
   localparam int unsigned F_FIX  = 9;
   localparam int unsigned F_PAD  = 10;

   typedef struct packed {
      logic       pad_en;
      logic       fix_hi;
      logic [2:0] outer;
      logic       layout;
      logic [2:0] inner;
      logic       mirror;
      logic       sel;
   } bank_cfg_t;

   function automatic bank_cfg_t unpack_reg(input logic [REG_W-1:0] r);
      bank_cfg_t c;
      c.pad_en = r[F_PAD];
      c.fix_hi = r[F_FIX];
      c.outer  = {r[F_OUT2], r[F_OUT1], r[F_OUT0]};
      c.layout = r[F_LAY];
      c.inner  = {r[F_IN2], r[F_IN1], r[F_IN0]};
      c.mirror = r[F_MIR];
      c.sel    = r[F_SEL];
      return c;
   endfunction
endpackage

// File: rtl/mcm_addr_latch.sv
module mcm_addr_latch #(
   parameter int unsigned CPU_AW = 16,
   parameter int unsigned REG_W  = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic [REG_W-1:0]  addr_lo,
   output logic [REG_W-1:0]  q
);
   if (REG_W >= CPU_AW) begin : g_bad_width
      $error("register must be narrower than the CPU address");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (wr_hit) q <= addr_lo;
   end

   a_r1_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> q == $past(addr_lo));
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit |=> $stable(q));
endmodule

// File: rtl/mcm_prg_map.sv
module mcm_prg_map
   import mcm_pkg::*;
#(
   parameter int unsigned PRG_AW = 20,
   parameter int unsigned PAD_W  = 4,
   parameter int unsigned WIN_W  = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bank_cfg_t         cfg,
   input  logic              cpu_hi,
   input  logic [WIN_W-1:0]  cpu_win,
   input  logic [PAD_W-1:0]  pads,
   output logic [PRG_AW-1:0] prg_addr
);
   localparam int unsigned BANK_W = 3;
   localparam int unsigned OUT_W  = 3;

   if (PRG_AW != WIN_W + BANK_W + OUT_W) begin : g_bad_prg
      $error("PRG width must equal window + inner + outer bits");
   end
   if (PAD_W == 0 || PAD_W > WIN_W) begin : g_bad_pad
      $error("pad field width out of range");
   end

   logic [BANK_W-1:0] bank;
   logic [PAD_W-1:0]  low;

   always_comb begin
      if (!cpu_hi)         bank = {cfg.inner[2:1], cfg.inner[0] & ~cfg.sel};
      else if (cfg.layout) bank = {cfg.inner[2:1], cfg.inner[0] | cfg.sel};
      else                 bank = {BANK_W{cfg.fix_hi}};
   end

   for (genvar i = 0; i < PAD_W; i++) begin : g_pad_mux
      assign low[i] = cfg.pad_en ? pads[i] : cpu_win[i];
   end

   assign prg_addr = {cfg.outer, bank, cpu_win[WIN_W-1:PAD_W], low};

   a_r5_uniform: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_hi && !cfg.layout) |-> (bank == '0 || bank == '1));
   a_r3_even: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_hi && cfg.sel) |-> !prg_addr[WIN_W]);
   a_r4_odd: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_hi && cfg.layout && cfg.sel) |-> prg_addr[WIN_W]);
endmodule

// File: rtl/mcm_prg_mapper.sv
module mcm_prg_mapper
   import mcm_pkg::*;
#(
   parameter int unsigned CPU_AW = 16,
   parameter int unsigned PAD_W  = 4,
   parameter int unsigned PRG_AW = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CPU_AW-1:0] cpu_addr,
   input  logic              cpu_rw,
   input  logic              cpu_strobe,
   input  logic [PAD_W-1:0]  pad_sel,
   input  logic              ppu_a10,
   input  logic              ppu_a11,
   output logic [PRG_AW-1:0] prg_addr,
   output logic              prg_sel,
   output logic              ciram_a10,
   output logic              chr_wr_ok
);
   localparam int unsigned WIN_W = CPU_AW - 2;
   localparam int unsigned TOP   = CPU_AW - 1;

   if (CPU_AW != 16) begin : g_bad_cpu
      $error("CPU address must be 16 bits");
   end

   logic            in_rom, wr_hit;
   logic [REG_W-1:0] reg_q;
   bank_cfg_t       cfg;

   assign in_rom = cpu_strobe && cpu_addr[TOP];
   assign wr_hit = in_rom && !cpu_rw;
   assign prg_sel = in_rom && cpu_rw;

   mcm_addr_latch #(.CPU_AW(CPU_AW), .REG_W(REG_W)) u_latch (
      .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit),
      .addr_lo(cpu_addr[REG_W-1:0]), .q(reg_q));

   assign cfg = unpack_reg(reg_q);

   mcm_prg_map #(.PRG_AW(PRG_AW), .PAD_W(PAD_W), .WIN_W(WIN_W)) u_map (
      .clk(clk), .rst_n(rst_n), .cfg(cfg), .cpu_hi(cpu_addr[WIN_W]),
      .cpu_win(cpu_addr[WIN_W-1:0]), .pads(pad_sel), .prg_addr(prg_addr));

   assign ciram_a10 = cfg.mirror ? ppu_a11 : ppu_a10;
   assign chr_wr_ok = ~cfg.layout;

   a_r9_sel_read: assert property (@(posedge clk) disable iff (!rst_n)
      prg_sel |-> (cpu_rw && cpu_strobe && cpu_addr[TOP]));
   a_r7_chr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit |=> $stable(chr_wr_ok));
   a_r6_pass: assert property (@(posedge clk) disable iff (!rst_n)
      prg_addr[WIN_W-1:PAD_W] == cpu_addr[WIN_W-1:PAD_W]);
endmodule

// File: tb/tb_mcm_prg_mapper.sv
module tb_mcm_prg_mapper;
   logic        clk = 0;
   logic        rst_n = 0;
   logic [15:0] cpu_addr = '0;
   logic        cpu_rw = 1;
   logic        cpu_strobe = 0;
   logic [3:0]  pad_sel = '0;
   logic        ppu_a10 = 0, ppu_a11 = 0;
   logic [19:0] prg_addr;
   logic        prg_sel, ciram_a10, chr_wr_ok;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #5 clk = ~clk;

   mcm_prg_mapper dut (.*);

   function automatic logic [19:0] model(input logic [10:0] r, input logic [15:0] a,
                                         input logic [3:0] pad);
      logic [2:0] inner, outer, b;
      inner = r[4:2];
      outer = {r[8], r[6], r[5]};
      if (!a[14])     b = r[0] ? (inner & 3'd6) : inner;
      else if (r[7])  b = r[0] ? (inner | 3'd1) : inner;
      else            b = r[9] ? 3'd7 : 3'd0;
      return {outer, b, a[13:4], r[10] ? pad : a[3:0]};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a);
      @(negedge clk);
      cpu_addr = a; cpu_rw = 0; cpu_strobe = 1;
      @(negedge clk);
      cpu_strobe = 0; cpu_rw = 1;
   endtask

   task automatic rd_check(input logic [10:0] r, input logic [15:0] a, input string req);
      cpu_addr = a; cpu_rw = 1; cpu_strobe = 1;
      #1;
      chk(req, 32'(prg_addr), 32'(model(r, a, pad_sel)));
      chk("R9", 32'(prg_sel), 32'(a[15]));
      cpu_strobe = 0;
      #1;
      chk("R9", 32'(prg_sel), 0);
   endtask

   task automatic side_check(input logic [10:0] r);
      for (int k = 0; k < 4; k++) begin
         ppu_a10 = k[0]; ppu_a11 = k[1];
         #1;
         chk("R8", 32'(ciram_a10), 32'(r[1] ? k[1] : k[0]));
      end
      chk("R7", 32'(chr_wr_ok), 32'(!r[7]));
   endtask

   initial begin
      #3;
      chk("R10", 32'(prg_addr), 32'(model(11'd0, cpu_addr, pad_sel)));
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R10: both halves map bank 0 after reset
      @(negedge clk);
      rd_check(11'd0, 16'h8123, "R10");
      rd_check(11'd0, 16'hC456, "R10");
      side_check(11'd0);
      // R1 R3 R4 R5 R6: every register value
      for (int v = 0; v < 2048; v++) begin
         logic [10:0] r;
         r = 11'(v);
         wr(16'h8000 | 16'(v) | 16'((v * 7) & 16'h3800));
         pad_sel = 4'(v) ^ 4'hA;
         rd_check(r, 16'h8000 | 16'((v * 37) & 16'h3FFF), "R3");
         rd_check(r, 16'hC000 | 16'((v * 53) & 16'h3FFF), r[7] ? "R4" : "R5");
         rd_check(r, 16'hFFF0 | 16'(v & 15), "R6");
         side_check(r);
      end
      // R2: ignored accesses
      wr(16'h8000 | 16'h0591);
      wr(16'h7FFF);
      wr(16'h0000);
      @(negedge clk); cpu_addr = 16'hBFFF; cpu_rw = 1; cpu_strobe = 1;
      @(negedge clk); cpu_strobe = 0;
      pad_sel = 4'h3;
      rd_check(11'h591, 16'h8ABC, "R2");
      rd_check(11'h591, 16'hCABC, "R2");
      side_check(11'h591);
      // R10: mid-run reset
      @(negedge clk); rst_n = 0;
      @(negedge clk); rst_n = 1;
      rd_check(11'd0, 16'hC777, "R10");
      chk("R10", 32'(chr_wr_ok), 1);
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (150000) @(posedge clk);
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule